// File: doc/BRIEF.md
# Random-Access Single-Read SDRAM Scheduler

This block turns a stream of random read addresses into command pulses for a four-bank SDRAM that runs with a burst length of one. It remembers, for each bank, whether the bank is precharged and, if not, which row is open. For every request it picks one of three paths. A hit in the open row gets a read at once. A miss on a precharged bank gets an activate and then a read. A miss on a bank with another row open gets a precharge, then an activate, then a read. Bank-level timing is counted in clock cycles and set by parameters, and the scheduler waits whenever a spacing rule is not yet met.

A request is held on the input until `req_ready` rises, and `req_ready` rises only in the cycle the read command is committed. Read data comes back in request order. The memory drives its data bus a fixed CAS latency after each read, and the block marks that cycle with a one-cycle `resp_valid`. Writes, refresh and mode-register setup are handled elsewhere.

Top module: `sdram_rd_sched`

## Requirements
- R1: While reset is asserted no command, `req_ready` or `resp_valid` is high. In the first cycle after reset is released the block issues one precharge with `cmd_pre_all` high, and it accepts no request before that precharge.
- R2: A request whose row is already open in its bank is accepted with no precharge or activate in between. `cmd_rd` then appears in the next cycle.
- R3: A request to a precharged bank causes exactly one activate and no precharge before it is accepted.
- R4: A request to a bank that has a different row open causes exactly one precharge and then one activate before it is accepted.
- R5: Two activates, to any banks, are at least T_RRD cycles apart.
- R6: Two activates to the same bank are at least T_RC cycles apart.
- R7: A precharge to a bank comes at least T_RAS cycles after that bank's activate. An activate comes at least T_RP cycles after that bank's precharge. A read comes at least T_RCD cycles after its bank's activate.
- R8: `resp_valid` is high exactly T_CL cycles after each `cmd_rd`. `resp_data` carries `dram_dq` in that cycle, and responses come back in request order.
- R9: At most one of `cmd_act`, `cmd_pre` and `cmd_rd` is high in any cycle.
- R10: `req_addr` is split into three fields. The bank is the top two bits, the row is the next ROW_W bits, and the column is the low COL_W bits. The command outputs carry these fields.
- R11: Requests that hit the same open row are accepted one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| req_valid | input | 1 | read request present |
| req_ready | output | 1 | request accepted this cycle |
| req_addr | input | 2+ROW_W+COL_W | bank, row, column |
| cmd_act | output | 1 | activate command |
| cmd_pre | output | 1 | precharge command |
| cmd_pre_all | output | 1 | qualifies cmd_pre as all-bank |
| cmd_rd | output | 1 | read command |
| cmd_bank | output | 2 | bank of the command |
| cmd_row | output | ROW_W | row of an activate |
| cmd_col | output | COL_W | column of a read |
| dram_dq | input | DATA_W | memory read data bus |
| resp_valid | output | 1 | read data strobe |
| resp_data | output | DATA_W | read data |

## Verification
Commands are registered, so a command decided at a clock edge is visible in the cycle after it. Read data is due T_CL cycles after the cycle in which `cmd_rd` shows. The bench samples every output on the falling edge. It keeps a history of observed reads so that each `resp_valid` is compared against the read seen exactly T_CL cycles earlier. The spacing rules are measured as distances in falling-edge counts between observed commands. The number of precharges and activates between two accepts is compared with a row model that the bench updates at each accept.

// File: rtl/sdram_rd_sched.sv
module sdram_rd_sched #(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 9,
  parameter int DATA_W = 16,
  parameter int T_RP   = 2,
  parameter int T_RCD  = 2,
  parameter int T_CL   = 2,
  parameter int T_RRD  = 2,
  parameter int T_RC   = 7,
  parameter int T_RAS  = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ROW_W+COL_W+1:0]   req_addr,
  output logic                     cmd_act,
  output logic                     cmd_pre,
  output logic                     cmd_pre_all,
  output logic                     cmd_rd,
  output logic [1:0]               cmd_bank,
  output logic [ROW_W-1:0]         cmd_row,
  output logic [COL_W-1:0]         cmd_col,
  input  logic [DATA_W-1:0]        dram_dq,
  output logic                     resp_valid,
  output logic [DATA_W-1:0]        resp_data
);
  localparam int TMAX = T_RP + T_RCD + T_RRD + T_RC + T_RAS;
  localparam int CW   = $clog2(TMAX + 1);
  localparam logic [CW-1:0] K_RP  = CW'(T_RP);
  localparam logic [CW-1:0] K_RCD = CW'(T_RCD);
  localparam logic [CW-1:0] K_RRD = CW'(T_RRD);
  localparam logic [CW-1:0] K_RC  = CW'(T_RC);
  localparam logic [CW-1:0] K_RAS = CW'(T_RAS);

  logic                init_done;
  logic [3:0]          idle;
  logic [ROW_W-1:0]    open_row [4];
  logic [CW-1:0]       since_act [4];
  logic [CW-1:0]       since_pre [4];
  logic [CW-1:0]       since_any;
  logic [T_CL-1:0]     rd_pipe;

  wire [1:0]       bk  = req_addr[ROW_W+COL_W+1 -: 2];
  wire [ROW_W-1:0] row = req_addr[COL_W +: ROW_W];
  wire [COL_W-1:0] col = req_addr[COL_W-1:0];

  wire hit    = !idle[bk] && open_row[bk] == row;
  wire go_rd  = init_done && req_valid && hit && since_act[bk] >= K_RCD;
  wire go_pre = init_done && req_valid && !idle[bk] && !hit
                && since_act[bk] >= K_RAS;
  wire go_act = init_done && req_valid && idle[bk] && since_pre[bk] >= K_RP
                && since_act[bk] >= K_RC && since_any >= K_RRD;

  assign req_ready  = go_rd;
  assign resp_valid = rd_pipe[T_CL-1];
  assign resp_data  = dram_dq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_done   <= 1'b0;
      idle        <= '0;
      since_any   <= '1;
      cmd_act     <= 1'b0;
      cmd_pre     <= 1'b0;
      cmd_pre_all <= 1'b0;
      cmd_rd      <= 1'b0;
      cmd_bank    <= '0;
      cmd_row     <= '0;
      cmd_col     <= '0;
      rd_pipe     <= '0;
      for (int i = 0; i < 4; i++) begin
        open_row[i]  <= '0;
        since_act[i] <= '1;
        since_pre[i] <= '1;
      end
    end else begin
      cmd_act     <= 1'b0;
      cmd_pre     <= 1'b0;
      cmd_pre_all <= 1'b0;
      cmd_rd      <= 1'b0;
      rd_pipe[0]  <= cmd_rd;
      for (int i = 1; i < T_CL; i++) rd_pipe[i] <= rd_pipe[i-1];
      if (since_any != '1) since_any <= since_any + 1'b1;
      for (int i = 0; i < 4; i++) begin
        if (since_act[i] != '1) since_act[i] <= since_act[i] + 1'b1;
        if (since_pre[i] != '1) since_pre[i] <= since_pre[i] + 1'b1;
      end
      if (!init_done) begin
        init_done   <= 1'b1;
        cmd_pre     <= 1'b1;
        cmd_pre_all <= 1'b1;
        idle        <= '1;
        for (int i = 0; i < 4; i++) since_pre[i] <= CW'(1);
      end else if (go_rd) begin
        cmd_rd   <= 1'b1;
        cmd_bank <= bk;
        cmd_col  <= col;
      end else if (go_pre) begin
        cmd_pre       <= 1'b1;
        cmd_bank      <= bk;
        idle[bk]      <= 1'b1;
        since_pre[bk] <= CW'(1);
      end else if (go_act) begin
        cmd_act       <= 1'b1;
        cmd_bank      <= bk;
        cmd_row       <= row;
        idle[bk]      <= 1'b0;
        open_row[bk]  <= row;
        since_act[bk] <= CW'(1);
        since_any     <= CW'(1);
      end
    end
  end
endmodule

// File: rtl/sdram_rd_sched_chk.sv
module sdram_rd_sched_chk #(
  parameter int T_CL  = 2,
  parameter int T_RRD = 2,
  parameter int T_RAS = 5
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       cmd_act,
  input logic       cmd_pre,
  input logic       cmd_pre_all,
  input logic       cmd_rd,
  input logic [1:0] cmd_bank,
  input logic       resp_valid
);
  logic [7:0]      gap_any;
  logic [7:0]      gap_bk [4];
  logic            init_seen;
  logic [T_CL-1:0] rd_sh;
  wire  [7:0]      gap_sel = gap_bk[cmd_bank];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_any   <= 8'hff;
      init_seen <= 1'b0;
      rd_sh     <= '0;
      for (int i = 0; i < 4; i++) gap_bk[i] <= 8'hff;
    end else begin
      if (cmd_pre_all) init_seen <= 1'b1;
      rd_sh[0] <= cmd_rd;
      for (int i = 1; i < T_CL; i++) rd_sh[i] <= rd_sh[i-1];
      gap_any <= cmd_act ? 8'd1 : (gap_any == 8'hff ? gap_any : gap_any + 8'd1);
      for (int i = 0; i < 4; i++)
        gap_bk[i] <= (cmd_act && cmd_bank == 2'(i)) ? 8'd1 :
                     (gap_bk[i] == 8'hff ? gap_bk[i] : gap_bk[i] + 8'd1);
    end
  end

  // R9
  one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cmd_act, cmd_pre, cmd_rd}) <= 1);
  // R1
  init_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_act || cmd_rd) |-> init_seen);
  // R2
  rd_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> cmd_rd);
  // R5
  act_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_act |-> gap_any >= 8'(T_RRD));
  // R7
  ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pre && !cmd_pre_all) |-> gap_sel >= 8'(T_RAS));
  // R8
  resp_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid == rd_sh[T_CL-1]);
endmodule

bind sdram_rd_sched sdram_rd_sched_chk #(.T_CL(T_CL), .T_RRD(T_RRD), .T_RAS(T_RAS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .cmd_act(cmd_act), .cmd_pre(cmd_pre), .cmd_pre_all(cmd_pre_all),
  .cmd_rd(cmd_rd), .cmd_bank(cmd_bank), .resp_valid(resp_valid));

// File: tb/test_sdram_rd_sched.sv
`timescale 1ns/1ps
module test_sdram_rd_sched;
  localparam int ROW_W = 12, COL_W = 9, DW = 16;
  localparam int T_RP = 2, T_RCD = 2, T_CL = 2, T_RRD = 2, T_RC = 7, T_RAS = 5;
  localparam int AW = ROW_W + COL_W + 2;

  logic clk = 0, rst_n = 0, req_valid = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] dram_dq = '0;
  logic req_ready, cmd_act, cmd_pre, cmd_pre_all, cmd_rd, resp_valid;
  logic [1:0] cmd_bank;
  logic [ROW_W-1:0] cmd_row;
  logic [COL_W-1:0] cmd_col;
  logic [DW-1:0] resp_data;

  always #2.5 clk = ~clk;

  sdram_rd_sched #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DW), .T_RP(T_RP),
    .T_RCD(T_RCD), .T_CL(T_CL), .T_RRD(T_RRD), .T_RC(T_RC), .T_RAS(T_RAS)) i_sdram_rd_sched (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .cmd_act(cmd_act), .cmd_pre(cmd_pre),
    .cmd_pre_all(cmd_pre_all), .cmd_rd(cmd_rd), .cmd_bank(cmd_bank),
    .cmd_row(cmd_row), .cmd_col(cmd_col), .dram_dq(dram_dq),
    .resp_valid(resp_valid), .resp_data(resp_data));

  int checks = 0, fails = 0;
  logic [DW-1:0] exp_q[$];
  logic [AW-1:0] acc_q[$];
  int n_pre = 0, n_act = 0, cyc = 0;
  int last_act[4], last_pre[4], last_any;
  logic [ROW_W-1:0] mdl_row[4];
  logic [T_CL-1:0] rd_hist = '0;
  logic bopen[4];
  logic [ROW_W-1:0] brow[4];
  realtime last_acc = 0;

  function automatic logic [DW-1:0] hashv(logic [AW-1:0] a);
    return a[15:0] ^ {a[22:16], a[22:14]} ^ 16'h5A3C;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      last_act[i] = -100; last_pre[i] = -100; bopen[i] = 0; brow[i] = '0;
      mdl_row[i] = '0;
    end
    last_any = -100;
  end

  // monitor: memory model, timing rules, response scoreboard
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(resp_valid == rd_hist[T_CL-1], "R8 latency", int'(resp_valid), int'(rd_hist[T_CL-1]));
      if (resp_valid) begin
        if (exp_q.size() == 0) chk(0, "R8 extra response", 1, 0);
        else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          chk(resp_data == e, "R8 data/order", int'(resp_data), int'(e));
        end
      end
      rd_hist = {rd_hist[T_CL-2:0], cmd_rd};
      if (cmd_act || cmd_pre || cmd_rd)
        chk($countones({cmd_act, cmd_pre, cmd_rd}) == 1, "R9 one command",
            $countones({cmd_act, cmd_pre, cmd_rd}), 1);
      if (cmd_act) begin
        chk(cyc - last_any >= T_RRD, "R5 act-act any bank", cyc - last_any, T_RRD);
        chk(cyc - last_act[cmd_bank] >= T_RC, "R6 act-act same bank", cyc - last_act[cmd_bank], T_RC);
        chk(cyc - last_pre[cmd_bank] >= T_RP, "R7 pre-act", cyc - last_pre[cmd_bank], T_RP);
        last_any = cyc; last_act[cmd_bank] = cyc; mdl_row[cmd_bank] = cmd_row;
        n_act++;
      end
      if (cmd_pre && cmd_pre_all) for (int i = 0; i < 4; i++) last_pre[i] = cyc;
      if (cmd_pre && !cmd_pre_all) begin
        chk(cyc - last_act[cmd_bank] >= T_RAS, "R7 act-pre", cyc - last_act[cmd_bank], T_RAS);
        last_pre[cmd_bank] = cyc;
        n_pre++;
      end
      if (cmd_rd) begin
        logic [DW-1:0] v;
        logic [AW-1:0] a;
        chk(cyc - last_act[cmd_bank] >= T_RCD, "R7 act-rd", cyc - last_act[cmd_bank], T_RCD);
        if (acc_q.size() != 0) begin
          a = acc_q.pop_front();
          chk(cmd_bank == a[AW-1 -: 2] && cmd_col == a[COL_W-1:0], "R10 fields",
              int'({cmd_bank, cmd_col}), int'({a[AW-1 -: 2], a[COL_W-1:0]}));
        end else chk(0, "R2 unexpected read", 1, 0);
        v = hashv({cmd_bank, mdl_row[cmd_bank], cmd_col});
        fork
          begin
            automatic logic [DW-1:0] vv = v;
            repeat (T_CL) @(posedge clk);
            #1 dram_dq = vv;
          end
        join_none
      end
    end
  end

  task automatic send(logic [1:0] b, logic [ROW_W-1:0] r, logic [COL_W-1:0] c, bit chk_gap);
    logic [AW-1:0] a;
    int ep, ea;
    a = {b, r, c};
    @(negedge clk);
    req_valid = 1; req_addr = a;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    ep = (bopen[b] && brow[b] != r) ? 1 : 0;
    ea = (bopen[b] && brow[b] == r) ? 0 : 1;
    if (ep == 0 && ea == 0) chk(n_pre == 0 && n_act == 0, "R2 hit needs no pre/act", n_pre + n_act, 0);
    else if (ep == 0) chk(n_pre == 0 && n_act == 1, "R3 idle bank act only", n_pre * 10 + n_act, 1);
    else chk(n_pre == 1 && n_act == 1, "R4 miss pre then act", n_pre * 10 + n_act, 11);
    if (chk_gap) chk(($realtime - last_acc) == 5.0, "R11 one per cycle",
                     int'(($realtime - last_acc) / 5.0), 1);
    last_acc = $realtime;
    n_pre = 0; n_act = 0;
    bopen[b] = 1; brow[b] = r;
    exp_q.push_back(hashv(a));
    acc_q.push_back(a);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] x;
    repeat (4) @(negedge clk);
    chk(!req_ready && !cmd_act && !cmd_pre && !cmd_rd && !resp_valid, "R1 reset state",
        int'({req_ready, cmd_act, cmd_pre, cmd_rd, resp_valid}), 0);
    rst_n = 1; req_valid = 1; req_addr = {2'd0, 12'd5, 9'd3};
    #1 chk(!req_ready, "R1 no accept before init", int'(req_ready), 0);
    @(negedge clk);
    chk(cmd_pre && cmd_pre_all && !cmd_act && !cmd_rd, "R1 precharge all",
        int'({cmd_pre, cmd_pre_all}), 3);
    n_pre = 0; n_act = 0;
    send(2'd0, 12'd5, 9'd3, 0);    // R3
    send(2'd0, 12'd5, 9'd7, 1);    // R2, R11
    send(2'd0, 12'd5, 9'd8, 1);
    send(2'd0, 12'd5, 9'd9, 1);
    send(2'd1, 12'd9, 9'd1, 0);    // R3, R5
    send(2'd2, 12'd77, 9'd2, 0);
    send(2'd3, 12'hABC, 9'h1FF, 0);
    send(2'd0, 12'd6, 9'd4, 0);    // R4, R6, R7
    send(2'd0, 12'd5, 9'd0, 0);
    send(2'd3, 12'hABC, 9'd0, 0);  // R10 high bank, full row
    x = 32'h1234_5678;
    for (int k = 0; k < 60; k++) begin
      x = x * 32'd1103515245 + 32'd12345;
      send(x[17:16], 12'(x[21:20]), x[30:22], 0);
    end
    @(negedge clk); req_valid = 0;
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all responses returned", exp_q.size(), 0);
    finish_run();
  end
endmodule